// File: doc/BRIEF.md
# Split-Carry Event Counter

This block counts events in a wide counter that is split into a low section and a high section, so that the adder in each clock cycle stays short. When the low section rolls over, its carry is captured in a register and added into the high section on the following clock. That single-cycle carry pipeline lets the counter run at a clock rate set by the low section's adder alone.

Counting happens on each clock where both the run enable and the event strobe are high. The run enable can be dropped on any cycle, including the one right after a low-section rollover. A pending carry is always committed on the next clock, whether or not counting continues, so stopping never loses 2^LOW_W counts. The read port always presents a coherent full-width value. While a carry is still pending, the read port folds it into the high section combinationally, so software never sees a torn value.

A software write loads both sections in one clock and discards any pending carry. The write wins over a simultaneous event. When the high section wraps, a sticky overflow flag is set, and only reset clears it.

Top module: `split_evt_counter`

## Requirements
- R1: A synchronous reset clears the count and the overflow flag; after the reset edge `rd_data` is 0 and `ovf` is 0.
- R2: On each clock edge where `cnt_en` and `evt` are both 1 and `wr_en` is 0, the full count increases by exactly one, modulo 2^(LOW_W+HIGH_W).
- R3: Immediately after every clock edge, `rd_data` equals the exact number of counted events, including on the cycle where a low-to-high carry is pending.
- R4: Dropping `cnt_en` on the cycle that follows a low-section rollover does not lose the carry; the count stays exact on every later cycle.
- R5: The low LOW_W bits of `rd_data` equal the count modulo 2^LOW_W on every cycle, whatever the stop timing.
- R6: When `wr_en` is 1, the next value of `rd_data` is `wr_data`, even if `cnt_en` and `evt` are also 1 in that cycle.
- R7: A write on the cycle where a carry is pending discards that carry; the count after the write is exactly `wr_data` and stays there while idle.
- R8: The carry that wraps the high section from all ones to zero sets `ovf` on the same edge where it is committed. Once set, `ovf` stays 1 through counting and writes until reset.
- R9: An event strobe while `cnt_en` is 0, or `cnt_en` without an event, leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Run enable; counting occurs only while high |
| evt | input | 1 | Event strobe, one count per clock while high |
| wr_en | input | 1 | Software load strobe |
| wr_data | input | LOW_W+HIGH_W | Value loaded by a write |
| rd_data | output | LOW_W+HIGH_W | Coherent full count, pending carry included |
| ovf | output | 1 | Sticky flag, set when the high section wraps |

## Verification
A lost or duplicated intermediate carry appears at `rd_data` as an error of exactly 2^LOW_W. It shows on the first edge after the faulty commit, or, with the read-side merge, on the very edge the carry is created. A stale merge or a missing commit shows up as a jump of 2^LOW_W on the next idle cycle. A wrong write priority or a leaked pending carry after a write differs from `wr_data` within one or two edges. A missed or non-sticky overflow is visible on `ovf` on the commit edge, or on any later edge. The bench uses a 4-bit low section and a 3-bit high section. It sweeps every start value through a count-then-stop sequence and runs long pseudo-random enable and event patterns against an arithmetic model.

// File: rtl/split_evt_counter.sv
module split_evt_counter #(
  parameter int LOW_W  = 32,
  parameter int HIGH_W = 8,
  localparam int W     = LOW_W + HIGH_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         evt,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         ovf
);

  logic [LOW_W-1:0]  lo_q;
  logic [HIGH_W-1:0] hi_q;
  logic              cy_q;
  logic              ovf_q;

  wire bump    = cnt_en & evt;
  wire lo_full = &lo_q;
  wire hi_full = &hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '0;
      cy_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else if (wr_en) begin
      lo_q <= wr_data[LOW_W-1:0];
      hi_q <= wr_data[W-1:LOW_W];
      cy_q <= 1'b0;
    end else begin
      if (bump) lo_q <= lo_q + 1'b1;
      cy_q <= bump & lo_full;
      if (cy_q) begin
        hi_q <= hi_q + 1'b1;
        if (hi_full) ovf_q <= 1'b1;
      end
    end
  end

  assign rd_data = {hi_q + {{(HIGH_W-1){1'b0}}, cy_q}, lo_q};
  assign ovf     = ovf_q;

endmodule

module split_evt_counter_chk #(
  parameter int LOW_W  = 32,
  parameter int HIGH_W = 8,
  localparam int W     = LOW_W + HIGH_W
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic         evt,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data,
  input logic         ovf
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !ovf));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && cnt_en && evt) |=> rd_data == $past(rd_data) + 1'b1);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !(cnt_en && evt)) |=> $stable(rd_data));

  assert_write_load_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == $past(wr_data));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

endmodule

bind split_evt_counter split_evt_counter_chk #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .evt(evt), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .ovf(ovf)
);

// File: tb/tb_split_evt_counter.sv
module tb_split_evt_counter;
  localparam int LW = 4;
  localparam int HW = 3;
  localparam int W  = LW + HW;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst, cnt_en, evt, wr_en;
  logic [W-1:0] wr_data, rd_data;
  logic ovf;

  int checks = 0;
  int errors = 0;
  int m  = 0;
  bit mo = 0;
  bit wp = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  split_evt_counter #(.LOW_W(LW), .HIGH_W(HW)) dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .evt(evt), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ovf(ovf)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string req);
    checks++;
    if (rd_data !== W'(m)) begin
      errors++;
      $display("FAIL %s: rd_data actual %0d expected %0d", req, rd_data, m);
    end
    checks++;
    if (rd_data[LW-1:0] !== LW'(m)) begin
      errors++;
      $display("FAIL R5: low bits actual %0d expected %0d", rd_data[LW-1:0], m % (1 << LW));
    end
    checks++;
    if (ovf !== mo) begin
      errors++;
      $display("FAIL R8 (%s): ovf actual %0b expected %0b", req, ovf, mo);
    end
  endtask

  task automatic step(bit r, bit e, bit v, bit w, int d, string req);
    @(negedge clk);
    rst = r; cnt_en = e; evt = v; wr_en = w; wr_data = W'(d);
    @(posedge clk);
    #1;
    if (r) begin
      m = 0; mo = 0; wp = 0;
    end else if (w) begin
      m = d; wp = 0;
    end else begin
      if (wp) mo = 1;
      wp = 0;
      if (e && v) begin
        if (m == MAXV) wp = 1;
        m = (m + 1) & MAXV;
      end
    end
    check(req);
  endtask

  initial begin
    rst = 1; cnt_en = 0; evt = 0; wr_en = 0; wr_data = '0;
    step(1, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, "R1");

    for (int i = 0; i < 300; i++) step(0, 1, 1, 0, 0, "R2/R3");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R8");

    step(1, 0, 0, 0, 0, "R1");
    for (int v = 0; v <= MAXV; v++) begin
      step(0, 0, 0, 1, v, "R6");
      step(0, 1, 1, 0, 0, "R2");
      step(0, 0, 1, 0, 0, "R4/R9");
      step(0, 1, 0, 0, 0, "R4/R9");
      step(0, 0, 0, 0, 0, "R4");
    end

    step(1, 0, 0, 0, 0, "R1");
    step(0, 1, 1, 1, 77, "R6");
    step(0, 0, 0, 1, 15, "R6");
    step(0, 1, 1, 0, 0, "R3");
    step(0, 0, 0, 1, 50, "R7");
    step(0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R7");

    step(0, 0, 0, 1, MAXV, "R6");
    step(0, 1, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 5, "R8");
    step(0, 1, 1, 0, 0, "R8");
    step(1, 0, 0, 0, 0, "R1");

    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(0, lf[0] | lf[1], lf[2] | lf[3], (lf[7:4] == 4'h0), int'(lf[14:8]), "R3");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule